// File: doc/BRIEF.md
# Reconfigurable Hierarchical Multiplier

This block is a purely combinational unsigned multiplier with two precisions. In byte mode it multiplies two 8-bit operands into a 16-bit product. In nibble mode it multiplies only the low four bits of each operand, and the result lands in the low byte of the product.

The product is built in three levels. The first level is four 4x4 sub-multipliers that run side by side. Each one forms its partial-product bits with AND gates, reduces them in a row of 4:2 compressors, and finishes with a small look-ahead adder. The second level places the four sub-products at their binary weights and reduces them to one sum row and one carry row, again with 4:2 compressors. The third level is a 16-bit carry look-ahead adder made of 4-bit groups, which adds those two rows.

In nibble mode, both operands of the three upper sub-multipliers are forced to zero. Their logic then stays still, and their sub-products add nothing to the result.

Top module: `rmul_top`

## Requirements
- R1: With `wide_mode` = 1, `product` equals `op_a` * `op_b` as unsigned 8-bit numbers, for every operand pair.
- R2: With `wide_mode` = 0, `product[7:0]` equals `op_a[3:0]` * `op_b[3:0]`.
- R3: With `wide_mode` = 0, `product[15:8]` is zero.
- R4: With `wide_mode` = 0, bits `op_a[7:4]` and `op_b[7:4]` have no effect on `product`.
- R5: With `wide_mode` = 0, the three sub-multipliers that handle a high nibble get zero operands, so each of their sub-products is zero.
- R6: The product is the weighted sum of the four 8-bit sub-products: low*low at weight 1, the two cross terms at weight 16, and high*high at weight 256.
- R7: The final adder returns the sum of the level-two sum and carry rows exactly. No carry is lost off the top column of any compressor row or adder.
- R8: The block has no state. Changing `wide_mode` or an operand changes `product` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Multiplicand; only bits 3:0 are used in nibble mode |
| op_b | input | 8 | Multiplier; only bits 3:0 are used in nibble mode |
| wide_mode | input | 1 | 1 selects the 8x8 product, 0 selects the 4x4 product |
| product | output | 16 | Unsigned product |

## Verification
The hardest condition to create from the ports is nibble mode with non-zero high nibbles. Only in that case does a missing or incomplete isolation of the upper sub-multipliers leak into the result. The exhaustive 4-bit sweep therefore puts fresh random values in the upper nibbles of every pair, and a directed step flips `wide_mode` while keeping all-ones operands.

The second hard condition is a carry that runs the full length of the look-ahead chain. Operand pairs such as 0xFF*0xFF and 0xAA*0x55 are placed in the vector table for that. Other pairs isolate a single cross term, so that a wrong weight for one sub-product shows up on its own.

// File: rtl/rmul_pkg.sv
package rmul_pkg;
    localparam int NIB_W     = 4;
    localparam int OP_W      = 2 * NIB_W;
    localparam int SUBP_W    = 2 * NIB_W;
    localparam int PROD_W    = 2 * OP_W;
    localparam int SUB_CNT   = 4;
    localparam int CLA_GRP_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        nib_t x;
        nib_t y;
    } nib_pair_t;

    typedef enum logic {
        MODE_NIB  = 1'b0,
        MODE_BYTE = 1'b1
    } mode_e;
endpackage

// File: rtl/rmul_comp42.sv
module rmul_comp42 (
    input  logic x0,
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic s1_d;

    // first full adder: three row bits, cout does not depend on cin
    always_comb begin
        s1_d = x0 ^ x1 ^ x2;
        cout = (x0 & x1) | (x0 & x2) | (x1 & x2);
    end

    // second full adder: folds in the fourth bit and the lateral carry
    always_comb begin
        sum   = s1_d ^ x3 ^ cin;
        carry = (s1_d & x3) | (s1_d & cin) | (x3 & cin);
    end
endmodule

// File: rtl/rmul_csa42_row.sv
module rmul_csa42_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    input  logic [W-1:0] r3,
    output logic [W-1:0] sum_row,
    output logic [W-1:0] carry_row,
    output logic [1:0]   spill
);
    logic [W:0]   link;
    logic [W-1:0] col_c;

    assign link[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_col
        rmul_comp42 u_c42 (
            .x0    (r0[k]),
            .x1    (r1[k]),
            .x2    (r2[k]),
            .x3    (r3[k]),
            .cin   (link[k]),
            .sum   (sum_row[k]),
            .carry (col_c[k]),
            .cout  (link[k+1])
        );
    end

    assign carry_row = {col_c[W-2:0], 1'b0};
    assign spill     = {link[W], col_c[W-1]};
endmodule

// File: rtl/rmul_cla.sv
module rmul_cla #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int GW = rmul_pkg::CLA_GRP_W;
    localparam int NG = W / GW;

    logic [NG:0] grp_c;
    assign grp_c[0] = cin;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        logic [GW-1:0] g_d, p_d;
        logic [GW:0]   c_d;

        always_comb begin
            g_d = a[gi*GW +: GW] & b[gi*GW +: GW];
            p_d = a[gi*GW +: GW] ^ b[gi*GW +: GW];
            c_d[0] = grp_c[gi];
            c_d[1] = g_d[0] | (p_d[0] & c_d[0]);
            c_d[2] = g_d[1] | (p_d[1] & g_d[0]) | (p_d[1] & p_d[0] & c_d[0]);
            c_d[3] = g_d[2] | (p_d[2] & g_d[1]) | (p_d[2] & p_d[1] & g_d[0])
                   | (p_d[2] & p_d[1] & p_d[0] & c_d[0]);
            c_d[4] = g_d[3] | (p_d[3] & g_d[2]) | (p_d[3] & p_d[2] & g_d[1])
                   | (p_d[3] & p_d[2] & p_d[1] & g_d[0])
                   | (p_d[3] & p_d[2] & p_d[1] & p_d[0] & c_d[0]);
        end

        assign sum[gi*GW +: GW] = p_d ^ c_d[GW-1:0];
        assign grp_c[gi+1]      = c_d[GW];
    end

    assign cout = grp_c[NG];
endmodule

// File: rtl/rmul_sub_mult.sv
module rmul_sub_mult #(
    parameter int NW = rmul_pkg::NIB_W
) (
    input  logic [NW-1:0]   mul_x,
    input  logic [NW-1:0]   mul_y,
    output logic [2*NW-1:0] prod,
    output logic            spill
);
    localparam int RW = 2 * NW;

    logic [NW-1:0][RW-1:0] pp;
    logic [RW-1:0]         s_row, c_row;
    logic [1:0]            row_spill;
    logic                  add_cout;

    // AND array: one row per multiplier bit, shifted to its weight
    for (genvar i = 0; i < NW; i++) begin : g_pp
        assign pp[i] = {{NW{1'b0}}, mul_x & {NW{mul_y[i]}}} << i;
    end

    rmul_csa42_row #(.W(RW)) u_red (
        .r0        (pp[0]),
        .r1        (pp[1]),
        .r2        (pp[2]),
        .r3        (pp[3]),
        .sum_row   (s_row),
        .carry_row (c_row),
        .spill     (row_spill)
    );

    rmul_cla #(.W(RW)) u_add (
        .a    (s_row),
        .b    (c_row),
        .cin  (1'b0),
        .sum  (prod),
        .cout (add_cout)
    );

    assign spill = |{row_spill, add_cout};
endmodule

// File: rtl/rmul_top.sv
module rmul_top
    import rmul_pkg::*;
(
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              wide_mode,
    output logic [PROD_W-1:0] product
);
    logic [SUB_CNT-1:0][SUBP_W-1:0] sub_prod;
    logic [SUB_CNT-1:0][PROD_W-1:0] rows;
    logic [SUB_CNT-1:0]             sub_spill;
    logic [PROD_W-1:0]              sum_row, carry_row;
    logic [1:0]                     top_spill;
    logic                           cla_cout;
    logic                           ovf_any;

    // level 1: index bit 1 picks the high nibble of A, bit 0 that of B
    for (genvar j = 0; j < SUB_CNT; j++) begin : g_sub
        localparam int SH = NIB_W * ((j % 2) + (j / 2));
        nib_pair_t opnd_d;
        logic      en_d;

        always_comb begin
            en_d     = (j == 0) || (wide_mode == MODE_BYTE);
            opnd_d.x = (j / 2 != 0) ? op_a[OP_W-1:NIB_W] : op_a[NIB_W-1:0];
            opnd_d.y = (j % 2 != 0) ? op_b[OP_W-1:NIB_W] : op_b[NIB_W-1:0];
            if (!en_d) opnd_d = '0;
        end

        rmul_sub_mult #(.NW(NIB_W)) u_sub (
            .mul_x (opnd_d.x),
            .mul_y (opnd_d.y),
            .prod  (sub_prod[j]),
            .spill (sub_spill[j])
        );

        assign rows[j] = PROD_W'(sub_prod[j]) << SH;
    end

    // level 2: weighted sub-products to one sum row and one carry row
    rmul_csa42_row #(.W(PROD_W)) u_lvl2 (
        .r0        (rows[0]),
        .r1        (rows[1]),
        .r2        (rows[2]),
        .r3        (rows[3]),
        .sum_row   (sum_row),
        .carry_row (carry_row),
        .spill     (top_spill)
    );

    // level 3: carry-propagate addition
    rmul_cla #(.W(PROD_W)) u_lvl3 (
        .a    (sum_row),
        .b    (carry_row),
        .cin  (1'b0),
        .sum  (product),
        .cout (cla_cout)
    );

    assign ovf_any = |{sub_spill, top_spill, cla_cout};
endmodule

// File: rtl/rmul_chk.sv
module rmul_chk
    import rmul_pkg::*;
(
    input logic [OP_W-1:0]                  op_a,
    input logic [OP_W-1:0]                  op_b,
    input logic                             wide_mode,
    input logic [PROD_W-1:0]                product,
    input logic [SUB_CNT-1:0][SUBP_W-1:0]   sub_prod,
    input logic [PROD_W-1:0]                sum_row,
    input logic [PROD_W-1:0]                carry_row,
    input logic                             ovf_any
);
    always_comb begin
        // R1
        wide_product_chk: assert (!wide_mode ||
            product == PROD_W'(op_a) * PROD_W'(op_b));
        // R2
        narrow_low_chk: assert (wide_mode ||
            product[7:0] == 8'(op_a[3:0]) * 8'(op_b[3:0]));
        // R3
        narrow_high_zero_chk: assert (wide_mode || product[15:8] == 8'h00);
        // R5
        upper_idle_chk: assert (wide_mode ||
            (sub_prod[1] == '0 && sub_prod[2] == '0 && sub_prod[3] == '0));
        // R6
        weighted_sum_chk: assert (product ==
            PROD_W'(sub_prod[0]) + (PROD_W'(sub_prod[1]) << 4)
            + (PROD_W'(sub_prod[2]) << 4) + (PROD_W'(sub_prod[3]) << 8));
        // R7
        final_add_chk: assert (product == sum_row + carry_row);
        // R7
        no_spill_chk: assert (!ovf_any);
    end
endmodule

bind rmul_top rmul_chk i_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .wide_mode (wide_mode),
    .product   (product),
    .sub_prod  (sub_prod),
    .sum_row   (sum_row),
    .carry_row (carry_row),
    .ovf_any   (ovf_any)
);

// File: tb/test_rmul_top.sv
module test_rmul_top;
    logic        clk = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        wide_mode = 1'b0;
    logic [15:0] product;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    rmul_top i_rmul_top (
        .op_a      (op_a),
        .op_b      (op_b),
        .wide_mode (wide_mode),
        .product   (product)
    );

    // {mode, a, b, expected}
    localparam logic [32:0] VEC [13] = '{
        {1'b1, 8'hFF, 8'hFF, 16'hFE01},
        {1'b1, 8'h80, 8'h80, 16'h4000},
        {1'b1, 8'h0F, 8'hF0, 16'h0E10},
        {1'b1, 8'hF0, 8'h0F, 16'h0E10},
        {1'b1, 8'h01, 8'hFF, 16'h00FF},
        {1'b1, 8'h00, 8'hAB, 16'h0000},
        {1'b1, 8'h10, 8'h10, 16'h0100},
        {1'b0, 8'hFF, 8'hFF, 16'h00E1},
        {1'b0, 8'hF3, 8'h5C, 16'h0024},
        {1'b0, 8'h0A, 8'h0B, 16'h006E},
        {1'b1, 8'h0A, 8'h0B, 16'h006E},
        {1'b1, 8'hAA, 8'h55, 16'h3872},
        {1'b0, 8'hF0, 8'hF0, 16'h0000}
    };

    task automatic check(input string tag, input logic [15:0] exp);
        checks++;
        if (product !== exp) begin
            errors++;
            $display("FAIL %s mode=%b a=%h b=%h actual=%h expected=%h",
                     tag, wide_mode, op_a, op_b, product, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        wide_mode = m;
        op_a      = a;
        op_b      = b;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // start-up state: zero operands give a zero product (R3)
        repeat (2) @(negedge clk);
        #1;
        check("R3 start", 16'h0000);

        // vector table: R1 R2 R6 R7 corners
        for (int i = 0; i < 13; i++) begin
            apply(VEC[i][32], VEC[i][31:24], VEC[i][23:16]);
            check(VEC[i][32] ? "R1 R6 R7 table" : "R2 R3 table", VEC[i][15:0]);
        end

        // every 4-bit pair, with junk in the upper nibbles (R2 R3 R4 R5)
        for (int ai = 0; ai < 16; ai++) begin
            for (int bi = 0; bi < 16; bi++) begin
                logic [7:0] ra, rb;
                ra = {4'($urandom), 4'(ai)};
                rb = {4'($urandom), 4'(bi)};
                apply(1'b0, ra, rb);
                check("R2 R3 R4 R5 sweep", 16'(ai * bi));
            end
        end

        // random byte pairs against a reference product (R1)
        for (int n = 0; n < 10000; n++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            apply(1'b1, ra, rb);
            check("R1 random", 16'(ra) * 16'(rb));
        end

        // R8: mode flip changes the product with no clock edge in between
        apply(1'b1, 8'hFF, 8'hFF);
        check("R8 byte", 16'hFE01);
        wide_mode = 1'b0;
        #1;
        check("R8 nibble", 16'h00E1);
        op_a = 8'h07;
        #1;
        check("R8 operand", 16'h0069);

        // R4: only upper nibbles differ, product must not move
        apply(1'b0, 8'h35, 8'hC6);
        check("R4 first", 16'h001E);
        apply(1'b0, 8'hA5, 8'h06);
        check("R4 second", 16'h001E);

        // R6: each cross term alone
        apply(1'b1, 8'h10, 8'h01);
        check("R6 hi*lo", 16'h0010);
        apply(1'b1, 8'h01, 8'h10);
        check("R6 lo*hi", 16'h0010);
        apply(1'b1, 8'h20, 8'h30);
        check("R6 hi*hi", 16'h0600);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule